// File: doc/BRIEF.md
# SGI Per-Source Pending State Tracker

This block holds the pending and active state of sixteen software-generated interrupts for one target processor. Each interrupt keeps separate state for each of up to eight source processors, so there are 128 pending bits and 128 active bits. The SGI generation path sets pending bits through an event input. The acknowledge and end-of-interrupt logic sets and clears active bits through two more event inputs.

Software sees the pending bits through a bank of four 32-bit clear-pending registers on a simple memory-mapped bus with byte write strobes.

- Writing a one to a bit removes the pending state for that SGI and source.
- An active interrupt stays active when its pending state is removed.
- Read data comes back registered, one cycle after the request.

When affinity routing is enabled, the bank reads as zero and ignores writes. SGIs marked as not implemented by a parameter mask never hold state.

Top module: `sgi_pend_track`

## Requirements
- R1: Register n (n = 0..3) answers at byte offset 0xF10 + 4*n. Address bits [1:0] are ignored. Byte lane x (bits 8x+7:8x) of register n belongs to SGI 4n + x. Bit b within a lane belongs to source processor b. State bit index i = 8*sgi + src on `pend_o` and `act_o`.
- R2: A bus write clears the pending bit under every written 1 bit. A written 0 bit leaves its pending bit unchanged.
- R3: Only byte lanes whose `req_wstrb` bit is 1 are affected by a write.
- R4: Bus writes never change any active bit. Clearing pending on an active-and-pending interrupt leaves it active only. Active bits change only through the activate and deactivate events.
- R5: A read presented in cycle t returns `rd_valid` = 1 with `rd_data` after edge t. `rd_data` holds the register's pending bits as they were before that edge. Offsets outside the four registers read as 0.
- R6: While `aff_route_en` is 1, reads return 0 and bus writes change no state.
- R7: Bits of SGIs whose `IMPL_MASK` bit is 0 read as 0, ignore writes, and never become pending or active, including through events.
- R8: A valid set event sets pending bit {set_sgi, set_src}. If a bus clear hits the same bit in the same cycle, the bit ends up pending.
- R9: A valid activate event sets the active bit. A valid deactivate event clears it. If both hit the same bit in one cycle, the bit ends up active.
- R10: After reset, all pending and active bits are 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aff_route_en | input | 1 | Affinity routing enabled: bank reads zero, writes ignored |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the distributor window |
| req_wdata | input | 32 | Write data, 1 bits clear pending |
| req_wstrb | input | 4 | Byte write strobes |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| set_vld | input | 1 | Set-pending event valid |
| set_sgi | input | 4 | Set-pending SGI number |
| set_src | input | 3 | Set-pending source processor |
| act_vld | input | 1 | Activate event valid |
| act_sgi | input | 4 | Activate SGI number |
| act_src | input | 3 | Activate source processor |
| deact_vld | input | 1 | Deactivate event valid |
| deact_sgi | input | 4 | Deactivate SGI number |
| deact_src | input | 3 | Deactivate source processor |
| pend_o | output | 128 | Pending state, index 8*sgi+src |
| act_o | output | 128 | Active state, index 8*sgi+src |

## Verification
Two pairs of functions can land on the same state bit in one cycle:
- a bus clear and a set-pending event on a pending bit;
- an activate and a deactivate event on an active bit.

Directed steps drive each pair on the same SGI and source in the same cycle, and expect the bit left set. Random traffic mixes writes, reads and events with independently drawn indices, so the same collisions also occur by chance. A bench model applies the clear first and the set last, and every cycle's state and read data are compared with it.

// File: rtl/sgi_pend_track.sv
module sgi_pend_track #(
  parameter logic [15:0] IMPL_MASK = 16'hFFFF,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hF10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aff_route_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_wstrb,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              set_vld,
  input  logic [3:0]        set_sgi,
  input  logic [2:0]        set_src,
  input  logic              act_vld,
  input  logic [3:0]        act_sgi,
  input  logic [2:0]        act_src,
  input  logic              deact_vld,
  input  logic [3:0]        deact_sgi,
  input  logic [2:0]        deact_src,
  output logic [127:0]      pend_o,
  output logic [127:0]      act_o
);
  localparam int NSGI = 16;
  localparam int NSRC = 8;
  localparam int NREG = NSGI / 4;
  localparam int NBIT = NSGI * NSRC;
  localparam logic [ADDR_W-3:0] BASE_W = BASE_ADDR[ADDR_W-1:2];

  logic [NBIT-1:0] pend_q, act_q, impl_bits;
  logic [NBIT-1:0] clr_vec, set_vec, actv_vec, deact_vec;
  logic [NREG-1:0] reg_hit;
  logic            wr_go, rd_go;
  logic [31:0]     rd_mux;

  assign wr_go = req_valid & req_write & ~aff_route_en;
  assign rd_go = req_valid & ~req_write;

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_dec
      assign reg_hit[r] = req_addr[ADDR_W-1:2] == BASE_W + (ADDR_W-2)'(r);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NSGI; i++) impl_bits[i*NSRC +: NSRC] = {NSRC{IMPL_MASK[i]}};
  end

  always_comb begin
    clr_vec = '0;
    rd_mux  = '0;
    for (int n = 0; n < NREG; n++) begin
      if (reg_hit[n]) rd_mux = pend_q[n*32 +: 32];
      for (int x = 0; x < 4; x++)
        if (wr_go && reg_hit[n] && req_wstrb[x])
          clr_vec[(4*n+x)*NSRC +: NSRC] = req_wdata[8*x +: 8];
    end
  end

  assign set_vec   = set_vld   ? (NBIT'(1) << {set_sgi, set_src})     : '0;
  assign actv_vec  = act_vld   ? (NBIT'(1) << {act_sgi, act_src})     : '0;
  assign deact_vec = deact_vld ? (NBIT'(1) << {deact_sgi, deact_src}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      act_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pend_q   <= ((pend_q & ~clr_vec) | set_vec) & impl_bits;
      act_q    <= ((act_q & ~deact_vec) | actv_vec) & impl_bits;
      rd_valid <= rd_go;
      rd_data  <= (rd_go && !aff_route_en) ? rd_mux : '0;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld && IMPL_MASK[set_sgi] |=> pend_q[$past({set_sgi, set_src})]);

  // R9
  act_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld && IMPL_MASK[act_sgi] |=> act_q[$past({act_sgi, act_src})]);

  // R4
  act_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld && !deact_vld |=> $stable(act_q));

  // R6
  aff_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && aff_route_en |=> ($past(pend_q) & ~pend_q) == '0);

  // R6
  aff_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(aff_route_en) |-> rd_data == '0);

  // R7
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o | act_o) & ~impl_bits) == '0);
endmodule

// File: tb/sgi_pend_track_tb.sv
module sgi_pend_track_tb;
  localparam logic [15:0] MASK = 16'hBFFF;
  logic clk = 0, rst_n = 0, aff_route_en = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0] req_wstrb = 0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic set_vld = 0, act_vld = 0, deact_vld = 0;
  logic [3:0] set_sgi = 0, act_sgi = 0, deact_sgi = 0;
  logic [2:0] set_src = 0, act_src = 0, deact_src = 0;
  logic [127:0] pend_o, act_o, m_pend, m_act;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sgi_pend_track #(.IMPL_MASK(MASK)) u_dut (.*);

  function automatic int reg_of(logic [11:0] a);
    if (a[11:2] >= 10'h3C4 && a[11:2] <= 10'h3C7) return int'(a[11:2] - 10'h3C4);
    return -1;
  endfunction

  function automatic logic [31:0] exp_read();
    int n = reg_of(req_addr);
    if (aff_route_en || n < 0) return 32'h0;
    return m_pend[n*32 +: 32];
  endfunction

  task automatic model_step();
    int n = reg_of(req_addr);
    if (req_valid && req_write && !aff_route_en && n >= 0)
      for (int x = 0; x < 4; x++)
        if (req_wstrb[x])
          for (int b = 0; b < 8; b++)
            if (req_wdata[8*x+b]) m_pend[(4*n+x)*8+b] = 1'b0;
    if (set_vld && MASK[set_sgi]) m_pend[set_sgi*8+set_src] = 1'b1;
    if (deact_vld) m_act[deact_sgi*8+deact_src] = 1'b0;
    if (act_vld && MASK[act_sgi]) m_act[act_sgi*8+act_src] = 1'b1;
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [31:0] er = exp_read();
    logic rd = req_valid && !req_write;
    @(posedge clk); #1;
    model_step();
    chk({tag, " pend"}, pend_o, m_pend);
    chk({tag, " act"}, act_o, m_act);
    chk({tag, " rd_valid"}, 128'(rd_valid), 128'(rd));
    if (rd) chk({tag, " rd_data"}, 128'(rd_data), 128'(er));
    @(negedge clk);
    req_valid = 0; req_write = 0; set_vld = 0; act_vld = 0; deact_vld = 0;
  endtask

  task automatic wr(int n, logic [31:0] d, logic [3:0] s);
    req_valid = 1; req_write = 1; req_addr = 12'hF10 + 12'(4*n); req_wdata = d; req_wstrb = s;
  endtask

  task automatic rdq(logic [11:0] a);
    req_valid = 1; req_write = 0; req_addr = a;
  endtask

  task automatic setp(int s, int p);
    set_vld = 1; set_sgi = 4'(s); set_src = 3'(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_pend = '0; m_act = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 pend", pend_o, 128'h0);
    chk("R10 act", act_o, 128'h0);
    chk("R10 rd_valid", 128'(rd_valid), 128'h0);
    // R1 R8 R5: SGI 5 src 3 -> reg 1 lane 1 bit 3
    setp(5, 3); cyc("R8 set");
    rdq(12'hF14); cyc("R1 read");
    chk("R1 lane", 128'(rd_data), 128'h0000_0800);
    // R4 R2: active and pending, then clear
    act_vld = 1; act_sgi = 5; act_src = 3; cyc("R9 act");
    wr(1, 32'h0000_0800, 4'hF); cyc("R4 clr");
    chk("R4 stays active", 128'(act_o[43]), 128'h1);
    chk("R2 cleared", 128'(pend_o[43]), 128'h0);
    // R3 strobe off, R2 zero data
    setp(5, 3); cyc("R8 reset");
    wr(1, 32'h0000_0800, 4'hD); cyc("R3 strobe");
    wr(1, 32'hFFFF_F7FF, 4'hF); cyc("R2 zeros");
    chk("R3 R2 kept", 128'(pend_o[43]), 128'h1);
    // R8 collision
    setp(2, 6); cyc("R8 pre");
    wr(0, 32'h0040_0000, 4'h4); setp(2, 6); cyc("R8 collide");
    chk("R8 set wins", 128'(pend_o[22]), 128'h1);
    // R6 affinity routing
    aff_route_en = 1;
    wr(0, 32'hFFFF_FFFF, 4'hF); cyc("R6 wr");
    rdq(12'hF10); cyc("R6 rd");
    chk("R6 rd zero", 128'(rd_data), 128'h0);
    aff_route_en = 0;
    // R7 unimplemented SGI 14
    setp(14, 1); cyc("R7 set");
    act_vld = 1; act_sgi = 14; act_src = 1; cyc("R7 act");
    rdq(12'hF1C); cyc("R7 rd");
    chk("R7 lane zero", 128'(rd_data[23:16]), 128'h0);
    // R5 out of window and unaligned low bits
    rdq(12'hF20); cyc("R5 oow");
    rdq(12'hF0C); cyc("R5 below");
    rdq(12'hF16); cyc("R1 unaligned");
    // R9 collision
    act_vld = 1; deact_vld = 1; act_sgi = 9; act_src = 0; deact_sgi = 9; deact_src = 0;
    cyc("R9 collide");
    chk("R9 act wins", 128'(act_o[72]), 128'h1);
    deact_vld = 1; deact_sgi = 9; deact_src = 0; cyc("R9 deact");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      aff_route_en = ($urandom % 10) == 0;
      if ($urandom % 2) begin
        req_valid = 1; req_write = $urandom % 2;
        req_addr = ($urandom % 8 != 0) ? 12'hF10 + 12'($urandom % 16) : 12'($urandom);
        req_wdata = $urandom & $urandom & $urandom; req_wstrb = 4'($urandom);
      end
      set_vld = ($urandom % 10) < 6; set_sgi = 4'($urandom); set_src = 3'($urandom);
      act_vld = ($urandom % 10) < 3; act_sgi = 4'($urandom); act_src = 3'($urandom);
      deact_vld = ($urandom % 10) < 2; deact_sgi = 4'($urandom); deact_src = 3'($urandom);
      cyc("RND R2 R3 R5 R6 R8 R9");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule